// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block decides which transmit mailbox goes onto the CAN bus next. Every mailbox presents a 4-bit state code, a 29-bit identifier with its frame-format flag (extended or standard) and remote-request flag, and three local priority bits. A pulse on `arb_start` opens an arbitration run. The run lasts `RUN_LEN` cycles. When it closes, the block registers a winner flag and a winner index. These stay unchanged until the next run is started.

Two configuration pins select how priority is decided. In identifier mode, the lowest arbitration key wins, as a dominant bit wins on the bus. The key follows the on-wire order of the arbitration field, and the local priority bits can be placed above it. In mailbox-order mode, the identifier is ignored and the lowest-numbered pending mailbox wins. Only mailboxes holding the pending-transmit code can win. A mailbox whose control word the CPU writes while a run is open is left out of that run alone. The block's pins are plain control and status signals with no valid/ready handshake. `win_idx` carries meaning only while `win_valid` is high.

Top module: `can_tx_arbiter`

## Requirements
- R1: Only a mailbox whose code equals 4'b1100 is a candidate. Every other code, including the idle codes 4'b1000 and 4'b1001, never wins.
- R2: In identifier mode (`cfg_order_mode`=0), the candidate with the numerically lowest key wins. A standard identifier occupies bits 28:18 of its 29-bit `mb_id` slice, and the other bits of a standard frame are ignored.
- R3: The key follows bus order. A standard frame beats an extended frame with the same 11-bit base. A data frame beats a remote frame with the same identifier and format.
- R4: With `cfg_lprio_en`=1 in identifier mode, the 3-bit local priority sits above the identifier as the most significant part of the key, and lower values win. With `cfg_lprio_en`=0, the local priority is ignored.
- R5: In mailbox-order mode (`cfg_order_mode`=1), the lowest-indexed candidate wins, whatever its identifier, format or local priority.
- R6: When two candidates have equal keys, the lower mailbox index wins.
- R7: A mailbox whose `cpu_wr` bit is high in any cycle from the start cycle through the closing cycle of a run is excluded from that run. It takes part again in later runs.
- R8: A run that closes with no candidate leaves `win_valid` low.
- R9: `arb_start` is sampled only while no run is open, and is ignored during a run. The clock edge that samples it clears `win_valid`. The result is registered `RUN_LEN` edges after that edge, using the mailbox inputs present at that edge. After reset, `win_valid` is low.
- R10: Outside a run, `win_valid` and `win_idx` hold their values regardless of changes on the mailbox inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_order_mode | input | 1 | 1 = priority by mailbox index, 0 = priority by identifier key |
| cfg_lprio_en | input | 1 | Places the local priority bits above the identifier in the key |
| arb_start | input | 1 | Opens an arbitration run (pulse) |
| cpu_wr | input | NUM_MB | Per-mailbox strobe marking a CPU write to its control word |
| mb_code | input | 4*NUM_MB | Mailbox state codes, mailbox i at bits 4i+3:4i |
| mb_id | input | 29*NUM_MB | Identifiers, mailbox i at bits 29i+28:29i |
| mb_ide | input | NUM_MB | 1 = extended frame format |
| mb_rtr | input | NUM_MB | 1 = remote request frame |
| mb_lprio | input | 3*NUM_MB | Local priority, mailbox i at bits 3i+2:3i |
| win_valid | output | 1 | A winner was found in the last run |
| win_idx | output | $clog2(NUM_MB) | Index of the winning mailbox |

## Verification
The bench aims at the cases where the key encoding is easy to get wrong. These are a standard frame against an extended frame with the same base, a data frame against a remote frame, and local priority bits that must outweigh any identifier. An arbiter that compared raw identifiers would pick the extended or remote frame, or would ignore the local priority. Equal keys and mailbox-order mode test the tie-break: an upper-index preference would return the wrong index. CPU writes that land on the would-be winner in the first or the last cycle of a run test the exclusion window. A window that is one cycle short, or that clears too late, would either send the touched mailbox or lose it from the next run as well. A second start pulse inside a run, and input changes after a result, test that the result is held. A design that restarted or followed its inputs would drop `win_valid` or change `win_idx`.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  localparam int ID_W   = 29;
  localparam int LP_W   = 3;
  localparam int CODE_W = 4;
  localparam int ARB_W  = 32;
  localparam int KEY_W  = LP_W + ARB_W;

  localparam logic [CODE_W-1:0] CODE_TX_PEND = 4'b1100;

  // Arbitration field in bus order: base id, SRR/RTR slot, IDE, id extension, RTR.
  function automatic logic [ARB_W-1:0] arb_word(input logic [ID_W-1:0] id,
                                                 input logic ide, input logic rtr);
    if (!ide) arb_word = {id[28:18], rtr, 1'b0, 18'd0, 1'b0};
    else      arb_word = {id[28:18], 1'b1, 1'b1, id[17:0], rtr};
  endfunction
endpackage

// File: rtl/can_arb_keygen.sv
module can_arb_keygen
  import can_arb_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [ID_W-1:0]   id,
  input  logic              ide,
  input  logic              rtr,
  input  logic [LP_W-1:0]   lprio,
  input  logic              order_mode,
  input  logic              lprio_en,
  input  logic              excl,
  output logic              cand,
  output logic [KEY_W-1:0]  key
);
  assign cand = (code == CODE_TX_PEND) && !excl;

  always_comb begin
    if (order_mode) key = '0;   // all equal: index tie-break decides
    else            key = {(lprio_en ? lprio : {LP_W{1'b0}}), arb_word(id, ide, rtr)};
  end
endmodule

// File: rtl/can_arb_pick.sv
module can_arb_pick #(
  parameter int KEY_W = 35,
  parameter int IDX_W = 4
) (
  input  logic             a_vld,
  input  logic [KEY_W-1:0] a_key,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_vld,
  input  logic [KEY_W-1:0] b_key,
  input  logic [IDX_W-1:0] b_idx,
  output logic             y_vld,
  output logic [KEY_W-1:0] y_key,
  output logic [IDX_W-1:0] y_idx
);
  logic take_a;
  // a always holds the lower indices, so equal keys keep a
  assign take_a = a_vld && (!b_vld || (a_key <= b_key));
  assign y_vld  = a_vld | b_vld;
  assign y_key  = take_a ? a_key : b_key;
  assign y_idx  = take_a ? a_idx : b_idx;
endmodule

// File: rtl/can_arb_tree.sv
module can_arb_tree #(
  parameter int N     = 16,
  parameter int KEY_W = 35,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       leaf_vld,
  input  logic [N*KEY_W-1:0] leaf_key,
  output logic               best_vld,
  output logic [KEY_W-1:0]   best_key,
  output logic [IDX_W-1:0]   best_idx
);
  localparam int P = 1 << IDX_W;

  logic             nv [1:2*P-1];
  logic [KEY_W-1:0] nk [1:2*P-1];
  logic [IDX_W-1:0] ni [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign nv[P+i] = leaf_vld[i];
      assign nk[P+i] = leaf_key[i*KEY_W +: KEY_W];
      assign ni[P+i] = IDX_W'(i);
    end else begin : g_pad
      assign nv[P+i] = 1'b0;
      assign nk[P+i] = '0;
      assign ni[P+i] = '0;
    end
  end

  for (genvar n = 1; n < P; n++) begin : g_node
    can_arb_pick #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
      .a_vld(nv[2*n]),   .a_key(nk[2*n]),   .a_idx(ni[2*n]),
      .b_vld(nv[2*n+1]), .b_key(nk[2*n+1]), .b_idx(ni[2*n+1]),
      .y_vld(nv[n]),     .y_key(nk[n]),     .y_idx(ni[n])
    );
  end

  assign best_vld = nv[1];
  assign best_key = nk[1];
  assign best_idx = ni[1];
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
  import can_arb_pkg::*;
#(
  parameter int NUM_MB  = 16,
  parameter int RUN_LEN = 4,
  localparam int IDX_W  = $clog2(NUM_MB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_order_mode,
  input  logic                     cfg_lprio_en,
  input  logic                     arb_start,
  input  logic [NUM_MB-1:0]        cpu_wr,
  input  logic [NUM_MB*CODE_W-1:0] mb_code,
  input  logic [NUM_MB*ID_W-1:0]   mb_id,
  input  logic [NUM_MB-1:0]        mb_ide,
  input  logic [NUM_MB-1:0]        mb_rtr,
  input  logic [NUM_MB*LP_W-1:0]   mb_lprio,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx
);
  localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_MB-1:0] excl_q;
  logic [NUM_MB-1:0] excl_now;
  logic              run_done;

  logic [NUM_MB-1:0]       cand;
  logic [NUM_MB*KEY_W-1:0] keys;
  logic                    tree_vld;
  logic [KEY_W-1:0]        tree_key;
  logic [IDX_W-1:0]        tree_idx;

  assign excl_now = busy ? (excl_q | cpu_wr) : '0;
  assign run_done = busy && (cnt == '0);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    can_arb_keygen u_key (
      .code      (mb_code[i*CODE_W +: CODE_W]),
      .id        (mb_id[i*ID_W +: ID_W]),
      .ide       (mb_ide[i]),
      .rtr       (mb_rtr[i]),
      .lprio     (mb_lprio[i*LP_W +: LP_W]),
      .order_mode(cfg_order_mode),
      .lprio_en  (cfg_lprio_en),
      .excl      (excl_now[i]),
      .cand      (cand[i]),
      .key       (keys[i*KEY_W +: KEY_W])
    );
  end

  can_arb_tree #(.N(NUM_MB), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_tree (
    .leaf_vld(cand),
    .leaf_key(keys),
    .best_vld(tree_vld),
    .best_key(tree_key),
    .best_idx(tree_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      excl_q    <= '0;
      win_valid <= 1'b0;
      win_idx   <= '0;
    end else if (!busy) begin
      if (arb_start) begin
        busy      <= 1'b1;
        cnt       <= CNT_W'(RUN_LEN - 1);
        excl_q    <= cpu_wr;
        win_valid <= 1'b0;
      end
    end else begin
      excl_q <= excl_q | cpu_wr;
      if (cnt == '0) begin
        busy      <= 1'b0;
        win_valid <= tree_vld;
        win_idx   <= tree_idx;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    run_done && tree_vld |-> mb_code[tree_idx*CODE_W +: CODE_W] == CODE_TX_PEND); // R1
  AST_KEY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    run_done && tree_vld |-> keys[tree_idx*KEY_W +: KEY_W] == tree_key); // R2
  AST_WIN_NOT_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    run_done && tree_vld |-> !cpu_wr[tree_idx] && !excl_q[tree_idx]); // R7
  AST_NONE_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_done && (cand == '0) |=> !win_valid); // R8
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    arb_start && !busy |=> !win_valid); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !arb_start |=> $stable(win_valid) && $stable(win_idx)); // R10
endmodule

// File: tb/can_tx_arbiter_tb.sv
`timescale 1ns/100ps
module can_tx_arbiter_tb;
  localparam int N  = 16;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_order_mode = 1'b0;
  logic cfg_lprio_en = 1'b0;
  logic arb_start = 1'b0;
  logic [N-1:0] cpu_wr = '0;
  logic [N*4-1:0]  mb_code;
  logic [N*29-1:0] mb_id;
  logic [N-1:0]    mb_ide;
  logic [N-1:0]    mb_rtr;
  logic [N*3-1:0]  mb_lprio;
  logic            win_valid;
  logic [3:0]      win_idx;

  logic [3:0]  code  [N];
  logic [28:0] id    [N];
  logic        ide   [N];
  logic        rtr   [N];
  logic [2:0]  lprio [N];
  logic [N-1:0] wr_sched [RL+1];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mb_code[i*4 +: 4]   = code[i];
      mb_id[i*29 +: 29]   = id[i];
      mb_ide[i]           = ide[i];
      mb_rtr[i]           = rtr[i];
      mb_lprio[i*3 +: 3]  = lprio[i];
    end
  end

  can_tx_arbiter #(.NUM_MB(N), .RUN_LEN(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_order_mode(cfg_order_mode),
    .cfg_lprio_en(cfg_lprio_en), .arb_start(arb_start), .cpu_wr(cpu_wr),
    .mb_code(mb_code), .mb_id(mb_id), .mb_ide(mb_ide), .mb_rtr(mb_rtr),
    .mb_lprio(mb_lprio), .win_valid(win_valid), .win_idx(win_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench-side key from the requirement text: bus-order field, lprio on top
  function automatic logic [34:0] bkey(input int m);
    logic [31:0] f;
    if (cfg_order_mode) return '0;
    if (ide[m]) f = {id[m][28:18], 1'b1, 1'b1, id[m][17:0], rtr[m]};
    else        f = {id[m][28:18], rtr[m], 1'b0, 18'd0, 1'b0};
    return {(cfg_lprio_en ? lprio[m] : 3'd0), f};
  endfunction

  function automatic int ref_win(input logic [N-1:0] excl);
    int best = -1;
    for (int m = 0; m < N; m++)
      if (code[m] == 4'b1100 && !excl[m])
        if (best < 0 || bkey(m) < bkey(best)) best = m;
    return best;
  endfunction

  task automatic clear_mbs();
    for (int m = 0; m < N; m++) begin
      code[m] = 4'b1000; id[m] = '0; ide[m] = 1'b0; rtr[m] = 1'b0; lprio[m] = '0;
    end
    for (int j = 0; j <= RL; j++) wr_sched[j] = '0;
  endtask

  function automatic logic [28:0] sid(input int base);
    return {11'(base), 18'd0};
  endfunction

  // Runs one arbitration, optionally with an extra start in cycle 2, checks result
  task automatic run(input string req, input bit extra_start);
    logic [N-1:0] ex;
    int exp;
    ex = '0;
    for (int j = 0; j <= RL; j++) ex |= wr_sched[j];
    @(negedge clk);
    arb_start = 1'b1; cpu_wr = wr_sched[0];
    for (int j = 1; j <= RL; j++) begin
      @(negedge clk);
      if (j == 1) chk(win_valid == 1'b0, "R9 cleared by start", win_valid, 0);
      arb_start = (extra_start && j == 2);
      cpu_wr = wr_sched[j];
    end
    @(negedge clk);
    arb_start = 1'b0; cpu_wr = '0;
    exp = ref_win(ex);
    chk(win_valid == (exp >= 0), req, win_valid, exp >= 0);
    if (exp >= 0) chk(int'(win_idx) == exp, req, win_idx, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    clear_mbs();
    repeat (3) @(negedge clk);
    chk(win_valid == 1'b0, "R9 reset state", win_valid, 0);
    rst_n = 1'b1;

    // R1/R8: no pending code anywhere
    for (int m = 0; m < N; m++) code[m] = 4'(m == 12 ? 4'b1001 : (m % 8));
    run("R8 no candidate", 1'b0);
    chk(win_valid == 1'b0, "R1 idle codes never win", win_valid, 0);

    // R1: idle mailbox has lowest id
    clear_mbs();
    code[0] = 4'b1000; id[0] = sid(1);
    code[1] = 4'b1001; id[1] = sid(1);
    code[5] = 4'b1100; id[5] = sid(400);
    code[9] = 4'b1100; id[9] = sid(300);
    run("R1 only pending code", 1'b0);

    // R2: lowest key wins, low bits of standard ignored
    clear_mbs();
    code[2] = 4'b1100; id[2] = sid(50) | 29'h3FFFF;
    code[6] = 4'b1100; id[6] = sid(51);
    code[11] = 4'b1100; id[11] = sid(60);
    run("R2 lowest id", 1'b0);

    // R3: standard beats extended same base
    clear_mbs();
    code[3] = 4'b1100; id[3] = sid(77); ide[3] = 1'b1;
    code[7] = 4'b1100; id[7] = sid(77); rtr[7] = 1'b1;
    run("R3 std beats ext", 1'b0);
    // R3: data beats remote same id
    clear_mbs();
    code[4] = 4'b1100; id[4] = sid(90); rtr[4] = 1'b1;
    code[8] = 4'b1100; id[8] = sid(90);
    run("R3 data beats remote", 1'b0);

    // R4: local priority outweighs identifier
    clear_mbs();
    cfg_lprio_en = 1'b1;
    code[1] = 4'b1100; id[1] = sid(5);    lprio[1] = 3'd6;
    code[14] = 4'b1100; id[14] = sid(2000); lprio[14] = 3'd1;
    run("R4 lprio on top", 1'b0);
    cfg_lprio_en = 1'b0;
    run("R4 lprio ignored when off", 1'b0);

    // R5: mailbox order
    clear_mbs();
    cfg_order_mode = 1'b1;
    code[10] = 4'b1100; id[10] = sid(1);
    code[4]  = 4'b1100; id[4]  = sid(2000); ide[4] = 1'b1; lprio[4] = 3'd7;
    run("R5 lowest index", 1'b0);
    cfg_order_mode = 1'b0;

    // R6: equal keys
    clear_mbs();
    code[9] = 4'b1100; id[9] = sid(123);
    code[2] = 4'b1100; id[2] = sid(123);
    run("R6 tie to low index", 1'b0);

    // R7: write to winner in first cycle, then last cycle, then none
    clear_mbs();
    code[3] = 4'b1100; id[3] = sid(10);
    code[12] = 4'b1100; id[12] = sid(20);
    wr_sched[0] = 16'h0008;
    run("R7 write at start excludes", 1'b0);
    wr_sched[0] = '0; wr_sched[RL] = 16'h0008;
    run("R7 write at close excludes", 1'b0);
    wr_sched[RL] = '0;
    run("R7 next run includes", 1'b0);

    // R9: start during run ignored
    run("R9 start ignored in run", 1'b1);

    // R10: hold after result while inputs change
    code[3] = 4'b1000; code[0] = 4'b1100; cfg_order_mode = 1'b1;
    repeat (5) @(negedge clk);
    chk(win_valid == 1'b1, "R10 valid held", win_valid, 1);
    chk(win_idx == 4'd3, "R10 index held", win_idx, 3);
    cfg_order_mode = 1'b0;

    // Random runs
    for (int t = 0; t < 300; t++) begin
      for (int m = 0; m < N; m++) begin
        code[m]  = ($urandom_range(0, 1) == 1) ? 4'b1100 : 4'($urandom_range(0, 15));
        id[m]    = ($urandom_range(0, 1) == 1) ? 29'($urandom_range(0, 7)) << 26 : 29'($urandom());
        ide[m]   = 1'($urandom_range(0, 1));
        rtr[m]   = 1'($urandom_range(0, 1));
        lprio[m] = 3'($urandom_range(0, 7));
      end
      cfg_order_mode = ($urandom_range(0, 3) == 0);
      cfg_lprio_en   = 1'($urandom_range(0, 1));
      for (int j = 0; j <= RL; j++)
        wr_sched[j] = ($urandom_range(0, 2) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
      run("R2 R5 R6 R7 random", 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule